// File: doc/BRIEF.md
# I2C Target Controller with Transmit Queue

This block is the target side of an I2C link, attached to a faster system clock. It watches the serial clock and data lines and finds START and STOP conditions. It compares the first byte of a transfer with its own 7-bit address. On a write it delivers each received byte to local logic with a one-cycle strobe. On a read it sends bytes that local logic has queued in a small transmit FIFO. It drives the bus only through two open-drain enables: a 1 pulls the line low.

A read that arrives while the queue is empty is refused in the address acknowledge slot, and both lines are then left free so the controller can end the transfer. The acknowledge decision is taken before the acknowledge bit is clocked, so a byte queued during that slot cannot change the answer or leave the data line held low. If a later byte of a read finds the queue empty, the block can pause the bus by holding the clock low. Bit 6 of a control word turns this on. A change to that bit takes effect only while the clock line is low, so the clock line never shows a false edge.

Top module: `i2c_tgt`

## Requirements
- R1: After reset both open-drain enables are 0, `tx_empty` is 1, `tx_full` is 0, and `rx_valid` and `irq` are 0.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Only a first byte whose upper 7 bits equal `own_addr` is acknowledged. Any other address gets no acknowledge, and the bytes that follow have no effect on `rx_valid`.
- R3: In a write (first-byte LSB 0), every data byte is acknowledged. It appears MSB first on `rx_data` with a one-cycle `rx_valid` pulse, and `irq` pulses in the same cycle.
- R4: In a read (first-byte LSB 1), queued bytes are sent MSB first. SDA changes only while SCL is low. A NACK from the controller ends the read and releases SDA.
- R5: A read addressed to this target while the queue is empty is answered with NACK. After that slot, SDA and SCL are both released.
- R6: The acknowledge decision is fixed on the SCL falling edge that ends the eighth address bit. A push on the SCL rising edge of the acknowledge slot does not turn a NACK into an ACK, for any MSB value. SDA is free after the slot, and the pushed byte remains queued for the next read.
- R7: The queue holds 4 bytes in arrival order. `tx_full` rises on the fourth byte, and a push while full is dropped.
- R8: With control bit 6 set, a read byte that finds the queue empty after a controller ACK holds SCL low until a byte is pushed. That byte is then sent.
- R9: With control bit 6 clear, SCL is never driven low. A read byte that finds the queue empty is sent as 0xFF (SDA released).
- R10: A new value of control bit 6 is applied only while SCL is sampled low, and SCL is pulled low only while it is already low. Clearing the bit during a pause releases SCL, and 0xFF is sent.
- R11: `irq` also pulses once for each read byte that the controller acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | Target address |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word; bit 6 enables clock stretching |
| tx_push | input | 1 | Queue a transmit byte |
| tx_data | input | 8 | Byte to queue |
| tx_full | output | 1 | Queue holds 4 bytes |
| tx_empty | output | 1 | Queue holds no byte |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| irq | output | 1 | One-cycle event pulse (byte received or sent byte acknowledged) |

## Verification
The bench builds the block with its defaults: a 4-entry queue and a 2-stage synchronizer. With a depth of 4, the full flag and the dropped fifth push are reached with a handful of pushes. The 2-stage synchronizer keeps the lag between a bus edge and the block's reaction short, so a bench controller with quarter-bit phases of 12 cycles can place a push or a control write exactly on the acknowledge-slot edge and on every SCL phase.

// File: rtl/i2c_tgt_pkg.sv
// Shared types and constants for the I2C target.
package i2c_tgt_pkg;
    localparam int BYTE_W      = 8;
    localparam int ADDR_W      = 7;
    localparam int CTRL_W      = 8;
    localparam int STRETCH_BIT = 6;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ACK, ST_WR, ST_RD, ST_RDACK, ST_RDWAIT
    } tstate_e;

    typedef enum logic [1:0] {NX_IDLE, NX_WR, NX_RD} after_ack_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
// Line synchronizer and bus-condition detector.
// Brings SCL and SDA into the clk domain through STAGES flops each and reports
// SCL edges plus START/STOP. Assumes STAGES >= 2 and that SCL phases are much
// longer than STAGES clk cycles.
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic              scl_d, sda_d;

    // Shift the raw lines through the synchronizer chain (idle bus is high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
    assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_tgt_txfifo.sv
// Transmit byte queue.
// Circular buffer of DEPTH words; a push while full and a pop while empty are
// dropped. rdata shows the oldest word. Assumes DEPTH is a power of two.
module i2c_tgt_txfifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign rdata   = mem[rp];

    // Store an accepted word.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    // R7: a dropped push while full leaves the queue full.
    p_full_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> full);
endmodule

// File: rtl/i2c_tgt.sv
// I2C target with transmit queue and optional clock stretching.
// Decodes a 7-bit address, receives write bytes, and sends queued bytes on a
// read. An empty queue at a read address is NACKed. Clock stretching (control
// bit 6) is applied only while SCL is low. Assumes clk is far faster than SCL.
module i2c_tgt
    import i2c_tgt_pkg::*;
#(
    parameter int FIFO_DEPTH  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              tx_push,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_full,
    output logic              tx_empty,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              irq
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic pop;
    logic [BYTE_W-1:0] head;
    tstate_e    state;
    after_ack_e nxt;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sreg, txsr, rx_data_q;
    logic ack_drive, m_ack, loaded, rx_valid_q, irq_q;
    logic stretch_cfg, stretch_eff;
    logic unused_ctrl_bits;

    assign unused_ctrl_bits = ^{ctrl_wdata[CTRL_W-1:STRETCH_BIT+1], ctrl_wdata[STRETCH_BIT-1:0]};

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    i2c_tgt_txfifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_data),
        .pop(pop), .rdata(head), .full(tx_full), .empty(tx_empty)
    );

    // Control word: keep the stretch enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       stretch_cfg <= 1'b0;
        else if (ctrl_we) stretch_cfg <= ctrl_wdata[STRETCH_BIT];
    end

    // Apply the stretch enable only while SCL is low, so SCL cannot glitch.
    always_ff @(posedge clk) begin
        if (!rst_n)      stretch_eff <= 1'b0;
        else if (!scl_s) stretch_eff <= stretch_cfg;
    end

    // Take the head byte whenever the FSM loads a new transmit byte.
    always_comb begin
        pop = 1'b0;
        if (!bus_start && !bus_stop && !tx_empty) begin
            if (state == ST_ACK && scl_fall && nxt == NX_RD)  pop = 1'b1;
            if (state == ST_RDACK && scl_fall && m_ack)       pop = 1'b1;
            if (state == ST_RDWAIT && !loaded)                pop = 1'b1;
        end
    end

    // Transfer sequencer: address, acknowledge, write and read phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;  nxt <= NX_IDLE;  cnt <= '0;
            sreg <= '0;  txsr <= '1;  rx_data_q <= '0;
            ack_drive <= 1'b0;  m_ack <= 1'b0;  loaded <= 1'b0;
            rx_valid_q <= 1'b0;  irq_q <= 1'b0;
        end else begin
            rx_valid_q <= 1'b0;
            irq_q      <= 1'b0;
            if (bus_stop) begin
                state <= ST_IDLE;  ack_drive <= 1'b0;
            end else if (bus_start) begin
                state <= ST_ADDR;  cnt <= '0;  ack_drive <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WR: begin
                        if (scl_rise) begin
                            sreg <= {sreg[BYTE_W-2:0], sda_s};
                            cnt  <= cnt + 1'b1;
                        end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
                            if (state == ST_WR) begin
                                rx_data_q <= sreg;  rx_valid_q <= 1'b1;  irq_q <= 1'b1;
                                ack_drive <= 1'b1;  nxt <= NX_WR;  state <= ST_ACK;
                            end else if (sreg[BYTE_W-1:1] != own_addr) begin
                                state <= ST_IDLE;
                            end else begin
                                state <= ST_ACK;
                                if (!sreg[0])     begin ack_drive <= 1'b1; nxt <= NX_WR;   end
                                else if (tx_empty) begin ack_drive <= 1'b0; nxt <= NX_IDLE; end
                                else              begin ack_drive <= 1'b1; nxt <= NX_RD;   end
                            end
                        end
                    end
                    ST_ACK: if (scl_fall) begin
                        ack_drive <= 1'b0;  cnt <= '0;
                        case (nxt)
                            NX_WR:   state <= ST_WR;
                            NX_RD:   begin state <= ST_RD; txsr <= head; end
                            default: state <= ST_IDLE;
                        endcase
                    end
                    ST_RD: if (scl_fall) begin
                        if (cnt == CNT_W'(BYTE_W - 1)) begin
                            state <= ST_RDACK;  cnt <= '0;
                        end else begin
                            txsr <= {txsr[BYTE_W-2:0], 1'b1};  cnt <= cnt + 1'b1;
                        end
                    end
                    ST_RDACK: begin
                        if (scl_rise) m_ack <= !sda_s;
                        else if (scl_fall) begin
                            if (!m_ack) state <= ST_IDLE;
                            else begin
                                irq_q <= 1'b1;
                                if (!tx_empty)        begin txsr <= head; state <= ST_RD; end
                                else if (stretch_eff) begin state <= ST_RDWAIT; loaded <= 1'b0; end
                                else                  begin txsr <= '1; state <= ST_RD; end
                            end
                        end
                    end
                    ST_RDWAIT: begin
                        if (loaded)            state <= ST_RD;
                        else if (!tx_empty)    begin txsr <= head; loaded <= 1'b1; end
                        else if (!stretch_eff) begin txsr <= '1;   loaded <= 1'b1; end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Open-drain data drive for the current phase.
    always_comb begin
        case (state)
            ST_ACK:    sda_oe = ack_drive;
            ST_RD:     sda_oe = !txsr[BYTE_W-1];
            ST_RDWAIT: sda_oe = loaded && !txsr[BYTE_W-1];
            default:   sda_oe = 1'b0;
        endcase
    end

    assign scl_oe   = (state == ST_RDWAIT) && stretch_eff;
    assign rx_data  = rx_data_q;
    assign rx_valid = rx_valid_q;
    assign irq      = irq_q;

    // R3: the receive strobe lasts one cycle.
    p_rx_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R4: read data moves only while SCL is low.
    p_sda_moves_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD && !$stable(sda_oe)) |-> !scl_s);
    // R5: after a refused slot both lines are free.
    p_nack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state == ST_ACK && !ack_drive) && state != ST_ACK) |-> (!sda_oe && !scl_oe));
    // R6: the acknowledge answer is fixed for the whole slot.
    p_ack_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK && $past(state == ST_ACK)) |-> $stable(ack_drive));
    // R7: the sequencer never pops an empty queue.
    p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !tx_empty);
    // R9: stretching starts only when the control bit was set.
    p_stretch_needs_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> $past(stretch_cfg));
    // R10: SCL is pulled low only while already low.
    p_stretch_starts_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && !$past(scl_oe)) |-> !scl_s);
    // R10: the applied enable is frozen while SCL is high.
    p_enable_frozen_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(stretch_eff));
endmodule

// File: tb/tb_i2c_tgt.sv
`timescale 1ns/1ps
module tb_i2c_tgt;
    localparam int TQ = 12;
    localparam logic [6:0] ADDR = 7'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic scl_oe, sda_oe, scl_bus, sda_bus;
    logic ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic tx_push = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic tx_full, tx_empty, rx_valid, irq;
    logic [7:0] rx_data;

    int checks = 0, errors = 0;
    int rx_n = 0, irq_n = 0, scl_drv_n = 0, glitch_n = 0;
    logic [7:0] rx_log [16];
    logic oe_prev = 1'b0, bus_prev = 1'b1;
    logic ack_push_en = 1'b0;
    logic [7:0] ack_push_val = 8'h00;
    logic tog_done = 1'b0;

    always #2.5 clk = ~clk;

    assign scl_bus = !(m_scl_low || scl_oe);
    assign sda_bus = !(m_sda_low || sda_oe);

    i2c_tgt dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(ADDR),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_data(rx_data), .rx_valid(rx_valid), .irq(irq)
    );

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                if (rx_n < 16) rx_log[rx_n] = rx_data;
                rx_n++;
            end
            if (irq) irq_n++;
            if (scl_oe) scl_drv_n++;
            if (scl_oe && !oe_prev && bus_prev) glitch_n++;
        end
        oe_prev  = scl_oe;
        bus_prev = scl_bus;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic push_byte(input logic [7:0] d);
        tx_data = d; tx_push = 1'b1;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic ctrl_write(input logic [7:0] d);
        ctrl_wdata = d; ctrl_we = 1'b1;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; m_scl_low = 1'b0;
        wait_scl_high(); cyc(TQ);
        m_sda_low = 1'b1; cyc(TQ);
        m_scl_low = 1'b1; cyc(TQ);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; cyc(TQ);
        m_scl_low = 1'b0; wait_scl_high(); cyc(TQ);
        m_sda_low = 1'b0; cyc(2 * TQ);
    endtask

    task automatic put_bit(input logic b);
        m_sda_low = !b; cyc(TQ);
        m_scl_low = 1'b0; wait_scl_high(); cyc(TQ);
        m_scl_low = 1'b1; cyc(TQ);
    endtask

    task automatic get_bit(output logic b);
        m_sda_low = 1'b0; cyc(TQ);
        m_scl_low = 1'b0; wait_scl_high();
        if (ack_push_en) begin
            push_byte(ack_push_val);
            ack_push_en = 1'b0;
            cyc(TQ / 2 - 1);
        end else begin
            cyc(TQ / 2);
        end
        b = sda_bus; cyc(TQ / 2);
        m_scl_low = 1'b1; cyc(TQ);
    endtask

    task automatic put_byte(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        acked = !b;
    endtask

    task automatic get_byte(input logic ack_it, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(!ack_it);
    endtask

    task automatic t_reset();
        check("R1 scl_oe", scl_oe, 0);
        check("R1 sda_oe", sda_oe, 0);
        check("R1 tx_empty", tx_empty, 1);
        check("R1 tx_full", tx_full, 0);
        check("R1 rx_valid/irq", {rx_valid, irq}, 0);
    endtask

    task automatic t_write();
        logic a; int r0 = rx_n, i0 = irq_n;
        bus_start();
        put_byte({ADDR, 1'b0}, a); check("R2 own address ack", a, 1);
        put_byte(8'hC3, a);        check("R3 data ack 1", a, 1);
        put_byte(8'h5E, a);        check("R3 data ack 2", a, 1);
        bus_stop();
        check("R3 byte count", rx_n - r0, 2);
        check("R3 byte 1", rx_log[r0], 8'hC3);
        check("R3 byte 2", rx_log[r0 + 1], 8'h5E);
        check("R3 irq count", irq_n - i0, 2);
    endtask

    task automatic t_other_addr();
        logic a; int r0 = rx_n;
        bus_start();
        put_byte({7'h2B, 1'b0}, a); check("R2 foreign address nack", a, 0);
        put_byte(8'h77, a);         check("R2 ignored byte nack", a, 0);
        bus_stop();
        check("R2 no receive strobe", rx_n - r0, 0);
    endtask

    task automatic t_empty_read();
        logic a;
        bus_start();
        put_byte({ADDR, 1'b1}, a);   check("R5 empty read nack", a, 0);
        check("R5 lines released", {sda_oe, scl_oe}, 0);
        bus_stop();
        check("R5 bus idle", {sda_bus, scl_bus}, 2'b11);
    endtask

    task automatic t_read();
        logic a; logic [7:0] d; int i0;
        push_byte(8'h3C); push_byte(8'hA5);
        i0 = irq_n;
        bus_start();
        put_byte({ADDR, 1'b1}, a);   check("R4 read ack", a, 1);
        get_byte(1'b1, d);           check("R4 first byte", d, 8'h3C);
        get_byte(1'b0, d);           check("R4 second byte", d, 8'hA5);
        check("R4 sda free after nack", sda_oe, 0);
        bus_stop();
        check("R4 queue drained", tx_empty, 1);
        check("R11 irq on acked read byte", irq_n - i0, 1);
    endtask

    task automatic t_ack_edge_push(input logic [7:0] v);
        logic a; logic [7:0] d;
        ack_push_en = 1'b1; ack_push_val = v;
        bus_start();
        put_byte({ADDR, 1'b1}, a);   check("R6 decision kept nack", a, 0);
        check("R6 sda free after slot", sda_oe, 0);
        cyc(4 * TQ);
        check("R6 sda still free", {sda_oe, sda_bus}, 2'b01);
        bus_stop();
        check("R6 byte retained", tx_empty, 0);
        bus_start();
        put_byte({ADDR, 1'b1}, a);   check("R6 next read ack", a, 1);
        get_byte(1'b0, d);           check("R6 retained byte sent", d, v);
        bus_stop();
    endtask

    task automatic t_full();
        logic a; logic [7:0] d;
        push_byte(8'h11); push_byte(8'h22); push_byte(8'h33);
        check("R7 not full at 3", tx_full, 0);
        push_byte(8'h44);
        check("R7 full at 4", tx_full, 1);
        push_byte(8'h55);
        check("R7 still full", tx_full, 1);
        bus_start();
        put_byte({ADDR, 1'b1}, a);
        get_byte(1'b1, d); check("R7 order 1", d, 8'h11);
        get_byte(1'b1, d); check("R7 order 2", d, 8'h22);
        get_byte(1'b1, d); check("R7 order 3", d, 8'h33);
        get_byte(1'b0, d); check("R7 order 4, fifth dropped", d, 8'h44);
        bus_stop();
        check("R7 empty after four", tx_empty, 1);
    endtask

    task automatic t_no_stretch();
        logic a; logic [7:0] d;
        push_byte(8'h66);
        bus_start();
        put_byte({ADDR, 1'b1}, a);
        get_byte(1'b1, d); check("R9 queued byte", d, 8'h66);
        get_byte(1'b0, d); check("R9 empty gives FF", d, 8'hFF);
        bus_stop();
        check("R9 scl never driven", scl_drv_n, 0);
    endtask

    task automatic t_stretch();
        logic a; logic [7:0] d;
        ctrl_write(8'h40);
        push_byte(8'h81);
        bus_start();
        put_byte({ADDR, 1'b1}, a);
        get_byte(1'b1, d); check("R8 first byte", d, 8'h81);
        fork
            get_byte(1'b0, d);
            begin
                cyc(20 * TQ);
                check("R8 scl held", {scl_oe, scl_bus}, 2'b10);
                push_byte(8'h5A);
            end
        join
        check("R8 late byte sent", d, 8'h5A);
        bus_stop();
        push_byte(8'h01);
        bus_start();
        put_byte({ADDR, 1'b1}, a);
        get_byte(1'b1, d);
        fork
            get_byte(1'b0, d);
            begin
                cyc(20 * TQ);
                check("R10 pause active", scl_oe, 1);
                ctrl_write(8'h00);
            end
        join
        check("R10 cleared pause sends FF", d, 8'hFF);
        bus_stop();
        check("R10 scl released", scl_oe, 0);
    endtask

    task automatic t_toggle();
        logic a; logic [7:0] d1, d2;
        logic lvl; logic bitv = 1'b0;
        push_byte(8'hE7); push_byte(8'h18);
        tog_done = 1'b0;
        fork
            begin
                bus_start();
                put_byte({ADDR, 1'b1}, a);
                get_byte(1'b1, d1);
                get_byte(1'b0, d2);
                bus_stop();
                tog_done = 1'b1;
            end
            begin
                while (!tog_done) begin
                    lvl = scl_bus;
                    @(negedge clk);
                    if (scl_bus != lvl && !tog_done) begin
                        bitv = !bitv;
                        ctrl_write({1'b0, bitv, 6'b0});
                    end
                end
            end
        join
        ctrl_write(8'h00);
        check("R10 ack under toggling", a, 1);
        check("R10 byte 1 under toggling", d1, 8'hE7);
        check("R10 byte 2 under toggling", d2, 8'h18);
        check("R10 no scl glitch", glitch_n, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_write();
        t_other_addr();
        t_empty_read();
        t_read();
        t_ack_edge_push(8'h12);
        t_ack_edge_push(8'h9B);
        t_full();
        t_no_stretch();
        t_stretch();
        t_toggle();
        check("R10 no scl glitch overall", glitch_n, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule